// File: doc/BRIEF.md
# Shadow Metadata Address Translator

This block turns a 32-bit application data address into the address of the shadow metadata that describes it. A small fully associative table caches mappings from the upper 16 address bits to the base address of a metadata chunk covering 64 KiB of application space. The lower 16 bits give the position within that chunk. They are first shifted right to set how many application bytes share one metadata element, then shifted left by log2 of the element size. The element size is set on configuration inputs, so one table can serve monitors whose metadata sizes differ.

A lookup answers one cycle after the request with either a hit and the metadata address, or a miss with a zero address. On a miss the requester runs its own walk of the in-memory index, writes the result through the fill port and retries. A fill whose tag is already present replaces that entry in place. A fill with a new tag goes to the slot named by a round-robin pointer. A single invalidate input empties the whole table in one cycle.

The answer is held in a three-state response machine. RSP_IDLE means no answer is due, RSP_HIT means the last request matched, and RSP_MISS means it did not. From every state, a request that matches goes to RSP_HIT, a request that does not match goes to RSP_MISS, and a cycle with no request goes to RSP_IDLE.

Top module: `mdxlat_top`

## Requirements
- R1: After reset every entry is invalid and rsp_valid, rsp_hit, rsp_miss and rsp_maddr are all zero. A lookup right after reset misses.
- R2: rsp_valid is high in exactly the cycle after each cycle in which lk_valid is high. Back-to-back requests give back-to-back responses.
- R3: On a hit, rsp_maddr = base + ((lk_addr[15:0] >> cfg_gran_shift) << cfg_elem_log2), computed modulo 2^32. The base is the one stored for the tag lk_addr[31:16].
- R4: On a miss, rsp_miss is 1, rsp_hit is 0 and rsp_maddr is zero.
- R5: A fill whose tag matches a valid entry overwrites only that entry's base and does not advance the round-robin pointer.
- R6: A fill with a new tag writes the entry at the round-robin pointer, evicting the tag stored there. The pointer then advances by one, wrapping from 15 to 0.
- R7: inv_all clears every valid bit in one cycle and returns the round-robin pointer to entry 0.
- R8: When inv_all and fill_en are high in the same cycle, the fill is discarded.
- R9: A lookup issued in the same cycle as a fill sees the table as it was before that fill. The fill is visible to a lookup issued in the next cycle.
- R10: rsp_hit and rsp_miss are never both high, one of them is high whenever rsp_valid is high, and rsp_maddr is zero whenever rsp_valid is low.
- R11: cfg_gran_shift (0 to 15) and cfg_elem_log2 (0 to 3) are applied to the lookup made in the same cycle, for every combination of values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Application address to translate |
| cfg_gran_shift | input | 4 | Right shift applied to the low half of the address |
| cfg_elem_log2 | input | 2 | log2 of the metadata element size in bytes |
| fill_en | input | 1 | Write one table entry |
| fill_tag | input | 16 | Upper address half of the mapping being written |
| fill_base | input | 32 | Metadata chunk base of the mapping being written |
| inv_all | input | 1 | Invalidate every entry |
| rsp_valid | output | 1 | A response is present this cycle |
| rsp_hit | output | 1 | The request matched an entry |
| rsp_miss | output | 1 | The request matched no entry |
| rsp_maddr | output | 32 | Metadata address on a hit, zero otherwise |

## Verification
Every lookup result is due one cycle after its request: the match is captured at the rising edge that ends the request cycle. Fills and invalidates change the table at that same edge, so their effect first shows on the response to a request made in the following cycle. The bench drives inputs just after a falling edge and reads the response at the next falling edge, which is half a period after the capturing edge. The same-cycle cases (R8, R9) are arranged so that the rule "the request sees the old table" decides the expected value.

// File: rtl/mdx_pkg.sv
package mdx_pkg;

    // Response machine states
    typedef enum logic [1:0] {
        RSP_IDLE = 2'd0,
        RSP_HIT  = 2'd1,
        RSP_MISS = 2'd2
    } rsp_state_e;

endpackage

// File: rtl/mdx_rr_ptr.sv
module mdx_rr_ptr #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    output logic [IDX_W-1:0] ptr
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ptr_q <= '0;
        end else if (advance) begin
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    assign ptr = ptr_q;

endmodule

// File: rtl/mdx_tag_store.sv
module mdx_tag_store #(
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 16,
    parameter int BASE_W  = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic              fill_en,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [BASE_W-1:0] fill_base,
    input  logic              inv_all,
    input  logic [IDX_W-1:0]  victim,
    output logic              lk_hit,
    output logic [BASE_W-1:0] lk_base,
    output logic              fill_new
);

    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q  [ENTRIES];
    logic [BASE_W-1:0]  base_q [ENTRIES];

    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] fill_match;
    logic [ENTRIES-1:0] wr_sel;
    logic               fill_live;

    // One comparator pair per entry
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign lk_match[g]   = valid_q[g] && (tag_q[g] == lk_tag);
        assign fill_match[g] = valid_q[g] && (tag_q[g] == fill_tag);
    end

    assign fill_live = fill_en && !inv_all;
    assign fill_new  = fill_live && (fill_match == '0);
    assign lk_hit    = (lk_match != '0);

    always_comb begin
        lk_base = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            lk_base = lk_base | (base_q[i] & {BASE_W{lk_match[i]}});
        end
    end

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (fill_match != '0) begin
                wr_sel[i] = fill_live && fill_match[i];
            end else begin
                wr_sel[i] = fill_live && (victim == IDX_W'(i));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                valid_q[i] <= 1'b0;
                tag_q[i]   <= '0;
                base_q[i]  <= '0;
            end
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (inv_all) begin
                    valid_q[i] <= 1'b0;
                end else if (wr_sel[i]) begin
                    valid_q[i] <= 1'b1;
                    tag_q[i]   <= fill_tag;
                    base_q[i]  <= fill_base;
                end
            end
        end
    end

endmodule

// File: rtl/mdx_resp_fsm.sv
module mdx_resp_fsm
    import mdx_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic              lk_hit,
    input  logic [ADDR_W-1:0] lk_maddr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic [ADDR_W-1:0] rsp_maddr
);

    rsp_state_e        state_q, state_d;
    logic [ADDR_W-1:0] maddr_q;

    always_comb begin
        state_d = RSP_IDLE;
        unique case (state_q)
            RSP_IDLE, RSP_HIT, RSP_MISS: begin
                if (lk_valid) begin
                    state_d = lk_hit ? RSP_HIT : RSP_MISS;
                end
            end
            default: state_d = RSP_IDLE;
        endcase
    end

    // State register, with the address captured beside it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
            maddr_q <= '0;
        end else begin
            state_q <= state_d;
            maddr_q <= (lk_valid && lk_hit) ? lk_maddr : '0;
        end
    end

    // Outputs
    always_comb begin
        rsp_valid = 1'b0;
        rsp_hit   = 1'b0;
        rsp_miss  = 1'b0;
        rsp_maddr = '0;
        unique case (state_q)
            RSP_IDLE: ;
            RSP_HIT: begin
                rsp_valid = 1'b1;
                rsp_hit   = 1'b1;
                rsp_maddr = maddr_q;
            end
            RSP_MISS: begin
                rsp_valid = 1'b1;
                rsp_miss  = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mdxlat_top.sv
module mdxlat_top #(
    parameter int ADDR_W  = 32,
    parameter int TAG_W   = 16,
    parameter int ENTRIES = 16,
    parameter int GRAN_W  = 4,
    parameter int ELEM_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic [GRAN_W-1:0] cfg_gran_shift,
    input  logic [ELEM_W-1:0] cfg_elem_log2,
    input  logic              fill_en,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [ADDR_W-1:0] fill_base,
    input  logic              inv_all,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic [ADDR_W-1:0] rsp_maddr
);

    localparam int OFF_W = ADDR_W - TAG_W;
    localparam int IDX_W = $clog2(ENTRIES);

    logic [IDX_W-1:0]  victim;
    logic              fill_new;
    logic              lk_hit;
    logic [ADDR_W-1:0] lk_base;
    logic [OFF_W-1:0]  off_shr;
    logic [ADDR_W-1:0] off_scaled;
    logic [ADDR_W-1:0] lk_maddr;

    mdx_tag_store #(
        .ENTRIES (ENTRIES),
        .TAG_W   (TAG_W),
        .BASE_W  (ADDR_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_tag    (lk_addr[ADDR_W-1:OFF_W]),
        .fill_en   (fill_en),
        .fill_tag  (fill_tag),
        .fill_base (fill_base),
        .inv_all   (inv_all),
        .victim    (victim),
        .lk_hit    (lk_hit),
        .lk_base   (lk_base),
        .fill_new  (fill_new)
    );

    mdx_rr_ptr #(
        .ENTRIES (ENTRIES)
    ) u_rr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (inv_all),
        .advance (fill_new),
        .ptr     (victim)
    );

    // Granularity shift, then element-size scaling
    assign off_shr    = lk_addr[OFF_W-1:0] >> cfg_gran_shift;
    assign off_scaled = ADDR_W'(off_shr) << cfg_elem_log2;
    assign lk_maddr   = lk_base + off_scaled;

    mdx_resp_fsm #(
        .ADDR_W (ADDR_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_valid  (lk_valid),
        .lk_hit    (lk_hit),
        .lk_maddr  (lk_maddr),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit),
        .rsp_miss  (rsp_miss),
        .rsp_maddr (rsp_maddr)
    );

endmodule

// File: rtl/mdxlat_chk.sv
module mdxlat_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic              inv_all,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_miss,
    input logic [ADDR_W-1:0] rsp_maddr
);

    p_resp_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    p_quiet_without_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);

    p_miss_zero_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_maddr == '0));

    p_flags_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_hit, rsp_miss}));

    p_valid_has_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit || rsp_miss));

    p_idle_zero_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_maddr == '0));

    p_inv_then_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && $past(inv_all)) |=> rsp_miss);

endmodule

bind mdxlat_top mdxlat_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .inv_all   (inv_all),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_miss  (rsp_miss),
    .rsp_maddr (rsp_maddr)
);

// File: tb/mdxlat_top_test.sv
`timescale 1ns/1ps
module mdxlat_top_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_valid;
    logic [31:0] lk_addr;
    logic [3:0]  cfg_gran_shift;
    logic [1:0]  cfg_elem_log2;
    logic        fill_en;
    logic [15:0] fill_tag;
    logic [31:0] fill_base;
    logic        inv_all;
    logic        rsp_valid;
    logic        rsp_hit;
    logic        rsp_miss;
    logic [31:0] rsp_maddr;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    mdxlat_top uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .lk_valid       (lk_valid),
        .lk_addr        (lk_addr),
        .cfg_gran_shift (cfg_gran_shift),
        .cfg_elem_log2  (cfg_elem_log2),
        .fill_en        (fill_en),
        .fill_tag       (fill_tag),
        .fill_base      (fill_base),
        .inv_all        (inv_all),
        .rsp_valid      (rsp_valid),
        .rsp_hit        (rsp_hit),
        .rsp_miss       (rsp_miss),
        .rsp_maddr      (rsp_maddr)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] tag_of(input int i);
        return 16'h1000 + 16'(i * 37);
    endfunction

    function automatic logic [31:0] base_of(input int i);
        return 32'h4000_0000 + (32'(i) << 20);
    endfunction

    function automatic logic [31:0] exp_addr(input logic [31:0] base, input logic [15:0] lo,
                                             input int g, input int e);
        return base + ((32'(lo) >> g) << e);
    endfunction

    // All tasks are entered just after a falling edge and leave at one
    task automatic expect_hit(input logic [31:0] a, input logic [31:0] exp, input string req);
        lk_valid = 1'b1;
        lk_addr  = a;
        @(negedge clk);
        lk_valid = 1'b0;
        chk(rsp_valid && rsp_hit && !rsp_miss, {req, " hit flags"},
            {29'd0, rsp_valid, rsp_hit, rsp_miss}, 32'h6);
        chk(rsp_maddr == exp, {req, " metadata address"}, rsp_maddr, exp);
    endtask

    task automatic expect_miss(input logic [31:0] a, input string req);
        lk_valid = 1'b1;
        lk_addr  = a;
        @(negedge clk);
        lk_valid = 1'b0;
        chk(rsp_valid && rsp_miss && !rsp_hit, {req, " miss flags"},
            {29'd0, rsp_valid, rsp_hit, rsp_miss}, 32'h5);
        chk(rsp_maddr == 32'h0, {req, " miss address"}, rsp_maddr, 32'h0);
    endtask

    task automatic do_fill(input logic [15:0] t, input logic [31:0] b);
        fill_en   = 1'b1;
        fill_tag  = t;
        fill_base = b;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] lows [4];
        int          grans [4];
        lows[0] = 16'h0000; lows[1] = 16'h0004; lows[2] = 16'hFFFF; lows[3] = 16'h8A5C;
        grans[0] = 0; grans[1] = 2; grans[2] = 5; grans[3] = 15;

        rst_n = 1'b0; lk_valid = 1'b0; lk_addr = '0;
        cfg_gran_shift = 4'd2; cfg_elem_log2 = 2'd0;
        fill_en = 1'b0; fill_tag = '0; fill_base = '0; inv_all = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk(!rsp_valid && !rsp_hit && !rsp_miss, "R1 flags after reset",
            {29'd0, rsp_valid, rsp_hit, rsp_miss}, 32'h0);
        chk(rsp_maddr == 32'h0, "R1 address after reset", rsp_maddr, 32'h0);
        expect_miss(32'h1234_5678, "R1");

        for (int i = 0; i < 16; i++) do_fill(tag_of(i), base_of(i));

        // R3 R11: sweep over shifts, element sizes, entries and offsets
        for (int gi = 0; gi < 4; gi++) begin
            for (int e = 0; e < 4; e++) begin
                cfg_gran_shift = 4'(grans[gi]);
                cfg_elem_log2  = 2'(e);
                for (int i = 0; i < 16; i++) begin
                    for (int k = 0; k < 4; k++) begin
                        expect_hit({tag_of(i), lows[k]},
                                   exp_addr(base_of(i), lows[k], grans[gi], e), "R3 R11");
                    end
                end
            end
        end
        cfg_gran_shift = 4'd2;
        cfg_elem_log2  = 2'd0;

        // R4: unknown tag
        expect_miss(32'hDEAD_0010, "R4");

        // R2: back-to-back requests, then silence
        lk_valid = 1'b1;
        lk_addr  = {tag_of(4), 16'h0000};
        @(negedge clk);
        chk(rsp_valid && rsp_hit, "R2 first of pair", {30'd0, rsp_valid, rsp_hit}, 32'h3);
        lk_addr = 32'hBEEF_0000;
        @(negedge clk);
        chk(rsp_valid && rsp_miss, "R2 second of pair", {30'd0, rsp_valid, rsp_miss}, 32'h3);
        lk_valid = 1'b0;
        @(negedge clk);
        chk(!rsp_valid, "R2 no request", {31'd0, rsp_valid}, 32'h0);

        // R6: seventeenth new tag evicts entry 0 (first filled)
        do_fill(16'h7777, 32'h5000_0000);
        expect_miss({tag_of(0), 16'h0000}, "R6 evicted");
        expect_hit({tag_of(1), 16'h0000}, base_of(1), "R6 kept");
        expect_hit({16'h7777, 16'h0000}, 32'h5000_0000, "R6 new");

        // R8: invalidate and fill together, fill discarded
        inv_all   = 1'b1;
        fill_en   = 1'b1;
        fill_tag  = 16'h5555;
        fill_base = 32'h6000_0000;
        @(negedge clk);
        inv_all = 1'b0;
        fill_en = 1'b0;
        expect_miss({16'h5555, 16'h0000}, "R8");
        expect_miss({tag_of(3), 16'h0000}, "R7 cleared");
        expect_miss({16'h7777, 16'h0000}, "R7 cleared");

        // R7: pointer back at entry 0 after invalidate
        for (int i = 0; i < 16; i++) do_fill(16'h2000 + 16'(i), 32'h0800_0000 + 32'(i * 4096));
        do_fill(16'h3000, 32'h0A00_0000);
        expect_miss({16'h2000, 16'h0000}, "R7 pointer reset");
        expect_hit({16'h2001, 16'h0000}, 32'h0800_1000, "R6 neighbour kept");
        expect_hit({16'h3000, 16'h0000}, 32'h0A00_0000, "R6 new");

        // R5: overwrite in place, pointer does not move
        do_fill(16'h2005, 32'h0900_0000);
        expect_hit({16'h2005, 16'h0000}, 32'h0900_0000, "R5 new base");
        do_fill(16'h3001, 32'h0B00_0000);
        expect_miss({16'h2001, 16'h0000}, "R5 pointer held");
        expect_hit({16'h2002, 16'h0000}, 32'h0800_2000, "R5 neighbour kept");
        expect_hit({16'h3001, 16'h0040}, 32'h0B00_0010, "R5 fill after overwrite");

        // R9: lookup in the cycle of the fill sees the old table
        lk_valid  = 1'b1;
        lk_addr   = {16'h3002, 16'h0000};
        fill_en   = 1'b1;
        fill_tag  = 16'h3002;
        fill_base = 32'h0C00_0000;
        @(negedge clk);
        lk_valid = 1'b0;
        fill_en  = 1'b0;
        chk(rsp_valid && rsp_miss && !rsp_hit, "R9 same-cycle miss",
            {29'd0, rsp_valid, rsp_hit, rsp_miss}, 32'h5);
        expect_hit({16'h3002, 16'h0000}, 32'h0C00_0000, "R9 next cycle");

        @(negedge clk);
        chk(!rsp_valid && rsp_maddr == 32'h0, "R10 idle output", rsp_maddr, 32'h0);

        finish_run();
    end

endmodule